// File: doc/BRIEF.md
# Receive Pause Timer Controller

This block sits beside a MAC receive parser and turns accepted pause control frames into a hold-off signal for the local transmitter. For every parsed frame it takes the destination address, EtherType, opcode, pause quanta and a CRC-good flag, all presented with a one-cycle end-of-frame strobe. It qualifies the frame against a receive pause enable bit, the reserved pause multicast address and, optionally, the station's own unicast address. A qualified frame loads its quanta into a countdown timer.

The timer runs as a quanta register behind a cycle prescaler. One quanta is 512 bit times, which is 2**PRESCALE_W clock cycles; the default of 8 cycles suits a 64-bit datapath. The hold-off output rises as soon as a nonzero quanta is loaded. The transmitter treats it as a request not to start new data frames, so a frame already on the wire completes. The countdown stays frozen while the transmitter reports a data frame in progress, so the pause period starts when that frame ends. A later quanta replaces whatever time is left. A quanta of zero releases the pause at once.

Top module: `rx_pause_ctrl`

## Requirements
- R1: After rst_ni is released, pause_active_o is 0 until a pause frame is accepted.
- R2: A frame is accepted when frm_done_i=1, frm_crc_ok_i=1, rx_pause_en_i=1, frm_type_i=16'h8808, frm_opcode_i=16'h0001 and the address check of R3 passes. If the accepted quanta Q is nonzero and tx_busy_i=0, pause_active_o is 1 from the cycle after acceptance for exactly 8*Q cycles, and is 0 after that.
- R3: The address check passes when frm_dst_i equals 48'h0180C2000001 (first octet in the top byte). It also passes when ucast_en_i=1 and frm_dst_i equals station_addr_i. A frame sent to station_addr_i while ucast_en_i=0, or to any other address, is ignored.
- R4: With rx_pause_en_i=0, pause frames are ignored: pause_active_o and the remaining pause time stay as they were.
- R5: A frame with frm_crc_ok_i=0, an EtherType other than 16'h8808 or an opcode other than 16'h0001 is ignored.
- R6: pause_active_o is 1 from the cycle after a nonzero quanta is accepted, even while tx_busy_i=1. The countdown advances only in cycles with tx_busy_i=0, so the 8*Q cycles of pause count from the end of the current frame.
- R7: An accepted quanta overwrites the remaining time and restarts the prescaler, whether the new value is larger or smaller. The pause then lasts 8*Q_new counted cycles from the new load.
- R8: An accepted quanta of zero drives pause_active_o to 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frm_done_i | input | 1 | One-cycle strobe: parsed frame fields are valid |
| frm_crc_ok_i | input | 1 | Frame passed its CRC check |
| frm_dst_i | input | 48 | Destination address, first octet in bits 47:40 |
| frm_type_i | input | 16 | EtherType / length field |
| frm_opcode_i | input | 16 | MAC control opcode |
| frm_quanta_i | input | QUANTA_W | Pause quanta carried by the frame |
| station_addr_i | input | 48 | Local unicast station address |
| ucast_en_i | input | 1 | Accept pause frames sent to station_addr_i |
| rx_pause_en_i | input | 1 | Receive pause enable |
| tx_busy_i | input | 1 | Transmitter is sending a data frame |
| pause_active_o | output | 1 | Transmitter must not start a new data frame |

## Verification
The bench builds the block with its defaults, QUANTA_W=16 and PRESCALE_W=3. That gives eight cycles per quanta, so the prescaler boundary sits inside every pause window, and quanta of 1 to 10 keep each pause short enough to walk through cycle by cycle. A reference model counts the remaining pause cycles and predicts pause_active_o on every clock. This covers overwrites that land partway through a prescaler period, freezing during a busy frame, and zero-quanta release. The upper end of the 16-bit quanta range, more than half a million cycles, is outside what the bench reaches.

// File: rtl/pause_pkg.sv
package pause_pkg;
  localparam int unsigned ADDR_W = 48;
  localparam int unsigned FIELD_W = 16;

  localparam logic [ADDR_W-1:0]  PAUSE_MCAST_ADDR = 48'h0180C2000001;
  localparam logic [FIELD_W-1:0] CTRL_ETYPE       = 16'h8808;
  localparam logic [FIELD_W-1:0] PAUSE_OPCODE     = 16'h0001;

  typedef struct packed {
    logic [ADDR_W-1:0]  dst;
    logic [FIELD_W-1:0] etype;
    logic [FIELD_W-1:0] opcode;
  } ctrl_hdr_t;
endpackage

// File: rtl/pause_frame_filter.sv
module pause_frame_filter
  import pause_pkg::*;
(
  input  logic              done_i,
  input  logic              crc_ok_i,
  input  ctrl_hdr_t         hdr_i,
  input  logic [ADDR_W-1:0] station_addr_i,
  input  logic              ucast_en_i,
  input  logic              pause_en_i,
  output logic              accept_o
);
  logic addr_ok;
  logic hdr_ok;

  always_comb begin
    addr_ok = (hdr_i.dst == PAUSE_MCAST_ADDR) ||
              (ucast_en_i && (hdr_i.dst == station_addr_i));
    hdr_ok  = (hdr_i.etype == CTRL_ETYPE) && (hdr_i.opcode == PAUSE_OPCODE);
    accept_o = done_i && crc_ok_i && pause_en_i && addr_ok && hdr_ok;
  end
endmodule

// File: rtl/pause_quanta_timer.sv
module pause_quanta_timer #(
  parameter int unsigned QUANTA_W   = 16,
  parameter int unsigned PRESCALE_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [QUANTA_W-1:0] load_q_i,
  input  logic                busy_i,
  output logic                active_o
);
  logic [QUANTA_W-1:0] quanta_q;
  logic                count_en;
  logic                tick;

  assign active_o = (quanta_q != '0);
  // countdown frozen while a data frame is still going out
  assign count_en = active_o && !busy_i && !load_i;

  generate
    if (PRESCALE_W > 0) begin : g_pre
      localparam logic [PRESCALE_W-1:0] PRE_MAX = '1;
      logic [PRESCALE_W-1:0] pre_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       pre_q <= '0;
        else if (load_i)   pre_q <= '0;
        else if (count_en) pre_q <= pre_q + 1'b1;
      end

      assign tick = count_en && (pre_q == PRE_MAX);

      assert_busy_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && !load_i) |=> ($stable(pre_q) && $stable(quanta_q)));
      assert_load_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (pre_q == '0));
    end else begin : g_nopre
      assign tick = count_en;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     quanta_q <= '0;
    else if (load_i) quanta_q <= load_q_i;
    else if (tick)   quanta_q <= quanta_q - 1'b1;
  end

  assert_load_active_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && (load_q_i != '0)) |=> active_o);
  assert_zero_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && (load_q_i == '0)) |=> !active_o);
  assert_single_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ((quanta_q == $past(quanta_q)) || (quanta_q == $past(quanta_q) - 1'b1)));
endmodule

// File: rtl/rx_pause_ctrl.sv
module rx_pause_ctrl
  import pause_pkg::*;
#(
  parameter int unsigned QUANTA_W   = 16,
  parameter int unsigned PRESCALE_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frm_done_i,
  input  logic                frm_crc_ok_i,
  input  logic [47:0]         frm_dst_i,
  input  logic [15:0]         frm_type_i,
  input  logic [15:0]         frm_opcode_i,
  input  logic [QUANTA_W-1:0] frm_quanta_i,
  input  logic [47:0]         station_addr_i,
  input  logic                ucast_en_i,
  input  logic                rx_pause_en_i,
  input  logic                tx_busy_i,
  output logic                pause_active_o
);
  ctrl_hdr_t hdr;
  logic      accept;

  assign hdr = '{dst: frm_dst_i, etype: frm_type_i, opcode: frm_opcode_i};

  pause_frame_filter i_filter (
    .done_i         (frm_done_i),
    .crc_ok_i       (frm_crc_ok_i),
    .hdr_i          (hdr),
    .station_addr_i (station_addr_i),
    .ucast_en_i     (ucast_en_i),
    .pause_en_i     (rx_pause_en_i),
    .accept_o       (accept)
  );

  pause_quanta_timer #(
    .QUANTA_W   (QUANTA_W),
    .PRESCALE_W (PRESCALE_W)
  ) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .load_q_i (frm_quanta_i),
    .busy_i   (tx_busy_i),
    .active_o (pause_active_o)
  );

  assert_disabled_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_pause_en_i && !pause_active_o) |=> !pause_active_o);
  assert_bad_crc_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frm_crc_ok_i && !pause_active_o) |=> !pause_active_o);
  assert_no_strobe_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frm_done_i && !pause_active_o) |=> !pause_active_o);
endmodule

// File: tb/test_rx_pause_ctrl.sv
`timescale 1ns/1ps
module test_rx_pause_ctrl;
  localparam int QW = 16;
  localparam int PW = 3;
  localparam int CPQ = 1 << PW;
  localparam logic [47:0] MC  = 48'h0180C2000001;
  localparam logic [47:0] STA = 48'h02AB_CD00_1234;
  localparam logic [47:0] OTHER = 48'h0180C2000002;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_done = 0, frm_crc_ok = 0, ucast_en = 0, pause_en = 1, tx_busy = 0;
  logic [47:0] frm_dst = '0;
  logic [15:0] frm_type = '0, frm_opcode = '0;
  logic [QW-1:0] frm_quanta = '0;
  logic pause_active;

  always #2 clk = ~clk;

  rx_pause_ctrl #(.QUANTA_W(QW), .PRESCALE_W(PW)) i_rx_pause_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .frm_done_i(frm_done), .frm_crc_ok_i(frm_crc_ok),
    .frm_dst_i(frm_dst), .frm_type_i(frm_type), .frm_opcode_i(frm_opcode),
    .frm_quanta_i(frm_quanta), .station_addr_i(STA), .ucast_en_i(ucast_en),
    .rx_pause_en_i(pause_en), .tx_busy_i(tx_busy), .pause_active_o(pause_active));

  typedef struct { bit exp; string req; } item_t;
  item_t sb_q[$];
  int n_chk = 0, n_bad = 0, rem = 0;
  bit done_flag = 0;

  // monitor
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (pause_active !== it.exp) begin
        n_bad++;
        $display("FAIL %s: pause_active_o=%b expected %b at %0t", it.req, pause_active, it.exp, $time);
      end
    end
  end

  // driver: one cycle of stimulus plus model prediction
  task automatic step(input bit dn, input bit crc, input logic [47:0] dst,
                      input logic [15:0] typ, input logic [15:0] op,
                      input int q, input bit busy, input string req);
    bit acc;
    item_t it;
    @(negedge clk);
    frm_done = dn; frm_crc_ok = crc; frm_dst = dst; frm_type = typ;
    frm_opcode = op; frm_quanta = QW'(q); tx_busy = busy;
    acc = dn && crc && pause_en && typ == 16'h8808 && op == 16'h0001 &&
          (dst == MC || (ucast_en && dst == STA));
    if (acc) rem = q * CPQ;
    else if (rem > 0 && !busy) rem--;
    @(posedge clk);
    #1;
    it.exp = (rem > 0);
    it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n, input bit busy, input string req);
    for (int i = 0; i < n; i++) step(0, 1, '0, '0, '0, 0, busy, req);
  endtask

  task automatic pause(input logic [47:0] dst, input int q, input bit busy, input string req);
    step(1, 1, dst, 16'h8808, 16'h0001, q, busy, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4, 0, "R1");
    // idle pause
    pause(MC, 3, 0, "R2");
    idle(30, 0, "R2");
    // unicast accepted, then rejected
    ucast_en = 1;
    pause(STA, 2, 0, "R3");
    idle(20, 0, "R3");
    ucast_en = 0;
    pause(STA, 4, 0, "R3");
    idle(6, 0, "R3");
    pause(OTHER, 4, 0, "R3");
    idle(6, 0, "R3");
    // mid-frame pause
    idle(3, 1, "R6");
    pause(MC, 2, 1, "R6");
    idle(7, 1, "R6");
    idle(22, 0, "R6");
    // overwrite larger then smaller
    pause(MC, 2, 0, "R7");
    idle(5, 0, "R7");
    pause(MC, 5, 0, "R7");
    idle(45, 0, "R7");
    pause(MC, 6, 0, "R7");
    idle(11, 0, "R7");
    pause(MC, 1, 0, "R7");
    idle(12, 0, "R7");
    // zero quanta release
    pause(MC, 10, 0, "R8");
    idle(7, 0, "R8");
    pause(MC, 0, 0, "R8");
    idle(5, 0, "R8");
    // disabled enable bit, also while paused
    pause_en = 0;
    pause(MC, 4, 0, "R4");
    idle(5, 0, "R4");
    pause_en = 1;
    pause(MC, 3, 0, "R4");
    idle(4, 0, "R4");
    pause_en = 0;
    pause(MC, 0, 0, "R4");
    idle(25, 0, "R4");
    pause_en = 1;
    // bad crc, type, opcode
    step(1, 0, MC, 16'h8808, 16'h0001, 4, 0, "R5");
    idle(3, 0, "R5");
    step(1, 1, MC, 16'h0800, 16'h0001, 4, 0, "R5");
    idle(3, 0, "R5");
    step(1, 1, MC, 16'h8808, 16'h0101, 4, 0, "R5");
    idle(5, 0, "R5");
    while (sb_q.size() > 0) @(posedge clk);
    @(negedge clk);
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run incomplete, expected end before timeout");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule